// File: doc/BRIEF.md
# Three-Wire Nibble RTC Serial Master

This block is the controller side of a three-wire serial link to a real-time-clock chip. The link has a chip-enable line, a clock line that idles high, and one bidirectional data line. The data line is split here into a driven value, an output enable and a received value. A host on the system clock asks for one transfer at a time: a read or a write of a single 4-bit register, chosen by a 4-bit address.

Each transfer runs under one chip-enable window and always takes sixteen bit periods.

- A write sends an 8-bit command byte and then an 8-bit data byte. The data byte carries the nibble.
- A read sends the command byte, then releases the data line and clocks eight reply bits. Only the last four reply bits are kept.

A divider sets the length of each clock half-period in system clock cycles. When the transfer ends, the host sees a one-cycle completion pulse. For a read, the nibble is on `rdata` in that same cycle.

Top module: `rtc3w_master`

## Requirements
- R1: After reset, `ce` is low, `sclk` is high, `data_oe` is low, and `busy` and `done` are low.
- R2: Every transfer begins with a command byte, sent most significant bit first. From first bit to last it is: 1, the direction bit (1 = read, 0 = write), 1, 0, then the address bits 3, 2, 1 and 0.
- R3: `sclk` is high whenever `ce` is low. Each bit period is one half-period with `sclk` high and the bit value placed, then one half-period with `sclk` low. Every transfer has exactly 16 falling edges of `sclk`. The bit value is read at each falling edge.
- R4: In a write, the command byte is followed, under the same `ce` window, by the byte 1, 0, 0, 1 and then `wdata` bits 3, 2, 1 and 0, most significant first.
- R5: `data_oe` is high only while `ce` is high. It is high for all 16 bits of a write. In a read it is high for the first 8 bits and low for the last 8.
- R6: A read samples `data_in` at the falling edge of each of its last eight bits. The first four samples are discarded. The last four form `rdata`, first sample in bit 3. `rdata` is presented in the cycle in which `done` is high.
- R7: `ce` rises at least `HALF_DIV` system cycles before the first falling edge of `sclk`. It falls at least `HALF_DIV` cycles after the last rising edge.
- R8: `busy` is high from the cycle after an accepted `start` until `done`. `done` is high for exactly one cycle, with `ce` already low.
- R9: A `start` that arrives while `busy` is high is ignored. It does not change the frame in progress, and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a transfer (taken only when not busy) |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 4 | Register address |
| wdata | input | 4 | Nibble to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 4 | Nibble returned by the last read |
| ce | output | 1 | Chip enable to the clock chip |
| sclk | output | 1 | Serial clock, idles high |
| data_out | output | 1 | Value driven onto the data line |
| data_oe | output | 1 | Data line driven when high |
| data_in | input | 1 | Value received from the data line |

## Verification
The bench builds the block with `HALF_DIV` = 2. At that setting each half-period is two system cycles. A bench-side clock-chip model can then reply on the rising edge of `sclk` and have its bit settle well before the master's sampling edge. A transfer also finishes in about seventy cycles, so many address, data and reply patterns fit in a short run. This setting still separates the setup and hold windows of R7 from the single-cycle case, and it leaves room to inject a stray `start` partway through a frame.

// File: rtl/rtc3w_pkg.sv
package rtc3w_pkg;

    localparam int FRAME_BITS = 8;
    localparam int XFER_BITS  = 2 * FRAME_BITS;
    localparam int NIB_W      = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TAIL  = 2'd3
    } seq_state_e;

    // Command byte: marker 1, direction, address-flag 1, data-flag 0, address
    function automatic logic [FRAME_BITS-1:0] cmd_byte(input logic is_rd,
                                                       input logic [NIB_W-1:0] a);
        return {1'b1, is_rd, 1'b1, 1'b0, a};
    endfunction

    // Data byte: marker 1, write, address-flag 0, data-flag 1, nibble
    function automatic logic [FRAME_BITS-1:0] dat_byte(input logic [NIB_W-1:0] d);
        return {1'b1, 1'b0, 1'b0, 1'b1, d};
    endfunction

endpackage

// File: rtl/rtc3w_halfdiv.sv
module rtc3w_halfdiv #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    generate
        if (HALF_DIV <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_count
            localparam int CW = $clog2(HALF_DIV);
            localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (!run)
                    cnt_d = '0;
                else if (cnt_q == LAST)
                    cnt_d = '0;
                else
                    cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick = run && (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/rtc3w_seq.sv
module rtc3w_seq
    import rtc3w_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             rw,
    input  logic [NIB_W-1:0] addr,
    input  logic [NIB_W-1:0] wdata,
    input  logic             data_in,
    output logic             active,
    output logic             done,
    output logic [NIB_W-1:0] rdata,
    output logic             ce,
    output logic             sclk,
    output logic             data_out,
    output logic             data_oe
);
    localparam int BW = $clog2(XFER_BITS);
    localparam logic [BW-1:0] LAST_BIT = BW'(XFER_BITS - 1);

    typedef struct packed {
        seq_state_e           st;
        logic                 low_half;
        logic [BW-1:0]        bitn;
        logic [XFER_BITS-1:0] sreg;
        logic [NIB_W-1:0]     rx;
        logic                 is_rd;
        logic                 done;
        logic [NIB_W-1:0]     rdata;
    } seq_t;

    seq_t s_d, s_q;
    logic reply_phase;

    // Bits in the upper half of a read are driven by the slave
    assign reply_phase = s_q.bitn[BW-1];

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st       = ST_LEAD;
                    s_d.is_rd    = rw;
                    s_d.bitn     = '0;
                    s_d.low_half = 1'b0;
                    s_d.sreg     = {cmd_byte(rw, addr),
                                    rw ? {FRAME_BITS{1'b1}} : dat_byte(wdata)};
                end
            end
            ST_LEAD: begin
                if (tick) s_d.st = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!s_q.low_half) begin
                        s_d.low_half = 1'b1;
                        if (s_q.is_rd && reply_phase)
                            s_d.rx = {s_q.rx[NIB_W-2:0], data_in};
                    end else begin
                        s_d.low_half = 1'b0;
                        s_d.sreg     = {s_q.sreg[XFER_BITS-2:0], 1'b1};
                        if (s_q.bitn == LAST_BIT)
                            s_d.st = ST_TAIL;
                        else
                            s_d.bitn = s_q.bitn + 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                    if (s_q.is_rd) s_d.rdata = s_q.rx;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, low_half: 1'b0, bitn: '0, sreg: '1,
                     rx: '0, is_rd: 1'b0, done: 1'b0, rdata: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign active   = (s_q.st != ST_IDLE);
    assign done     = s_q.done;
    assign rdata    = s_q.rdata;
    assign ce       = active;
    assign sclk     = !((s_q.st == ST_SHIFT) && s_q.low_half);
    assign data_out = s_q.sreg[XFER_BITS-1];
    assign data_oe  = active && !(s_q.is_rd &&
                      ((s_q.st == ST_TAIL) || ((s_q.st == ST_SHIFT) && reply_phase)));
endmodule

// File: rtl/rtc3w_master.sv
module rtc3w_master #(
    parameter int HALF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       rw,
    input  logic [3:0] addr,
    input  logic [3:0] wdata,
    output logic       busy,
    output logic       done,
    output logic [3:0] rdata,
    output logic       ce,
    output logic       sclk,
    output logic       data_out,
    output logic       data_oe,
    input  logic       data_in
);
    logic active;
    logic tick;

    rtc3w_halfdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (active),
        .tick (tick)
    );

    rtc3w_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .start   (start),
        .rw      (rw),
        .addr    (addr),
        .wdata   (wdata),
        .data_in (data_in),
        .active  (active),
        .done    (done),
        .rdata   (rdata),
        .ce      (ce),
        .sclk    (sclk),
        .data_out(data_out),
        .data_oe (data_oe)
    );

    assign busy = active;
endmodule

// File: rtl/rtc3w_master_chk.sv
module rtc3w_master_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic ce,
    input logic sclk,
    input logic data_oe
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                           // R8
    AST_DONE_CE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ce && !busy));                                  // R8
    AST_OE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> ce);                                           // R5
    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |-> sclk);                                             // R3
    AST_CE_RISE_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce) |-> sclk);                                       // R7
    AST_CE_FALL_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce) |-> sclk);                                       // R7
    AST_START_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));                       // R9
endmodule

bind rtc3w_master rtc3w_master_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .ce     (ce),
    .sclk   (sclk),
    .data_oe(data_oe)
);

// File: tb/rtc3w_master_tb.sv
module rtc3w_master_tb;
    localparam int HD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, rw = 1'b0, data_in = 1'b1;
    logic [3:0] addr = '0, wdata = '0;
    logic busy, done, ce, sclk, data_out, data_oe;
    logic [3:0] rdata;

    int checks = 0, errors = 0;

    rtc3w_master #(.HALF_DIV(HD)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rw(rw), .addr(addr),
        .wdata(wdata), .busy(busy), .done(done), .rdata(rdata), .ce(ce),
        .sclk(sclk), .data_out(data_out), .data_oe(data_oe), .data_in(data_in)
    );

    always #5 clk = ~clk;

    // Clock-chip model and edge monitor, sampled at the falling system edge
    int          cyc = 0;
    logic        prev_sclk = 1'b1, prev_ce = 1'b0;
    logic [15:0] cap_bits, cap_oe;
    logic [7:0]  reply;
    int          falls, rises, t_ce_rise, t_first_fall, t_last_rise, t_ce_fall;

    task automatic mon_clear();
        cap_bits = '0; cap_oe = '0; falls = 0; rises = 0;
        t_ce_rise = -1; t_first_fall = -1; t_last_rise = -1; t_ce_fall = -1;
    endtask

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (ce && !prev_ce) t_ce_rise = cyc;
        if (!ce && prev_ce) t_ce_fall = cyc;
        if (!sclk && prev_sclk) begin
            if (falls == 0) t_first_fall = cyc;
            cap_bits = {cap_bits[14:0], data_out};
            cap_oe   = {cap_oe[14:0], data_oe};
            falls++;
        end
        if (sclk && !prev_sclk) begin
            rises++;
            t_last_rise = cyc;
            if (rises >= 8 && rises <= 15) data_in = reply[15-rises];
        end
        prev_sclk = sclk;
        prev_ce   = ce;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One transfer; optionally injects a stray start mid-frame (R9)
    task automatic run_xfer(input logic r, input logic [3:0] a, input logic [3:0] d,
                            input logic [7:0] rep, input bit stray);
        int waited = 0;
        logic [15:0] exp_bits, exp_oe;
        @(negedge clk);
        mon_clear();
        reply = rep;
        start = 1'b1; rw = r; addr = a; wdata = d;
        @(negedge clk);
        start = 1'b0;
        check("R8", "busy after start", busy, 1);
        while (!done && waited < 1000) begin
            @(negedge clk);
            waited++;
            if (stray && waited == 20) begin
                start = 1'b1; rw = ~r; addr = ~a; wdata = ~d;
            end else begin
                start = 1'b0;
            end
            if (!done) check("R8", "busy during transfer", busy, 1);
        end
        check("R8", "done seen", done, 1);
        check("R8", "ce low at done", ce, 0);
        if (r) check("R6", "rdata", rdata, rep[3:0]);
        @(negedge clk);
        check("R8", "done single cycle", done, 0);
        check("R3", "falling edge count", falls, 16);
        exp_oe = r ? 16'hFF00 : 16'hFFFF;
        check("R5", "oe pattern", cap_oe, exp_oe);
        exp_bits = {1'b1, r, 1'b1, 1'b0, a, 1'b1, 1'b0, 1'b0, 1'b1, d};
        check("R2", "command byte", cap_bits[15:8], exp_bits[15:8]);
        if (!r) check("R4", "data byte", cap_bits[7:0], exp_bits[7:0]);
        check("R7", "ce setup", (t_first_fall - t_ce_rise) >= HD, 1);
        check("R7", "ce hold", (t_ce_fall - t_last_rise) >= HD, 1);
        if (stray) begin
            repeat (30) @(negedge clk);
            check("R9", "no second transfer busy", busy, 0);
            check("R9", "no second transfer ce", ce, 0);
            check("R9", "no extra sclk edges", falls, 16);
        end
    endtask

    initial begin
        mon_clear();
        reply = '0;
        repeat (3) @(negedge clk);
        check("R1", "ce at reset", ce, 0);
        check("R1", "sclk at reset", sclk, 1);
        check("R1", "oe at reset", data_oe, 0);
        check("R1", "busy at reset", busy, 0);
        check("R1", "done at reset", done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R3", "sclk idle high", sclk, 1);

        run_xfer(1'b0, 4'h5, 4'hA, 8'h00, 1'b0);   // R4 write
        run_xfer(1'b0, 4'hF, 4'h0, 8'h00, 1'b0);   // R2 write, all-ones address
        run_xfer(1'b1, 4'h3, 4'h0, 8'hA6, 1'b0);   // R6 read -> 6
        run_xfer(1'b1, 4'hC, 4'h0, 8'h59, 1'b0);   // R6 read -> 9
        run_xfer(1'b1, 4'h0, 4'h0, 8'hF0, 1'b0);   // R6 leading bits discarded -> 0
        run_xfer(1'b1, 4'h9, 4'h0, 8'h0F, 1'b0);   // R6 -> F
        run_xfer(1'b0, 4'h6, 4'h3, 8'h00, 1'b1);   // R9 stray start during write
        run_xfer(1'b1, 4'hA, 4'h0, 8'h3C, 1'b1);   // R9 stray start during read

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule